// File: doc/BRIEF.md
# Sliding-Window Bit/Sample Cross-Correlator

This block keeps a running cross-correlation matrix between a set of antipodal training bits and the received chip samples of one bit period. The matrix has one row per bit lane and one column per chip sample. On each window step, the term of the newest bit period is folded in and the term of the period that leaves the window is taken out. After that step, every entry holds the sum over the window of bit times sample.

Each bit stands for +1 or -1, so no multiplier is needed. A sample enters an entry as itself or negated, and the bit picks which. One shared adder path walks the whole matrix, one entry per clock cycle, in row-major order. Each accumulator saturates at the signed 16-bit limits instead of wrapping.

Software or a neighbouring block reads any entry at any time through a combinational row/column read port. A busy flag shows when a sweep is in progress, and a one-cycle done pulse marks the end of the sweep.

Top module: `corr_xwin`

## Requirements
- R1: After reset, every matrix entry reads 0, and `busy` and `done` are low.
- R2: A `start` pulse while `busy` is low captures the four operand vectors. `busy` is high from the next cycle for exactly NUM_ROWS*NUM_COLS cycles. Operand inputs that change during the sweep have no effect on its result.
- R3: `done` is high for exactly one cycle, the first cycle in which `busy` is low again after a sweep. At that point every entry shows its updated value.
- R4: Each entry (r,c) gains t(bit_new[r], s_new[c]) - t(bit_old[r], s_old[c]). A bit value of 1 means +1 and 0 means -1, and t(b,s) is s for b=1 and -s for b=0. Sample c is the two's complement byte at bits [8c+7:8c] of its vector.
- R5: An entry whose sum would exceed 32767 becomes 32767. An entry whose sum would fall below -32768 becomes -32768.
- R6: A `start` pulse while `busy` is high is ignored. The sweep length and the final matrix are the same as without it.
- R7: The sweep writes one entry per cycle in row-major order, (0,0),(0,1)… then (1,0). Entry index k = r*NUM_COLS+c is written on the (k+1)-th cycle of `busy`. `rd_data` always shows the stored value of entry (`rd_row`,`rd_col`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a window step (taken only when idle) |
| bit_new | input | NUM_ROWS | Bits of the period entering the window (1=+1, 0=-1) |
| bit_old | input | NUM_ROWS | Bits of the period leaving the window |
| samp_new | input | NUM_COLS*8 | Chip samples entering the window, sample c at [8c+7:8c] |
| samp_old | input | NUM_COLS*8 | Chip samples leaving the window |
| rd_row | input | ROW_W | Read row index |
| rd_col | input | COL_W | Read column index |
| rd_data | output | 16 | Signed accumulator value at the read address |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle pulse after the last entry is written |

## Verification
The assertions assume that `start` is a clean synchronous level. They also assume that the read address has no effect on the write path. They do not assume that `start` is withheld while busy. The bench deliberately pulses `start` in the middle of a sweep, with different operands, to exercise the ignore path. The stimulus drives every input on the falling clock edge and reads the matrix only through the read port. Saturation runs push entries against both rails through many repeated steps.

// File: rtl/corr_pkg.sv
package corr_pkg;
  localparam int SAMP_W  = 8;
  localparam int ACC_W   = 16;
  localparam int TERM_W  = SAMP_W + 1;
  localparam int DELTA_W = SAMP_W + 2;

  typedef logic signed [SAMP_W-1:0]  samp_t;
  typedef logic signed [TERM_W-1:0]  term_t;
  typedef logic signed [DELTA_W-1:0] delta_t;
  typedef logic signed [ACC_W-1:0]   acc_t;

  localparam acc_t ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam acc_t ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  // Antipodal product: bit 1 keeps the sample, bit 0 negates it.
  function automatic term_t signed_term(input logic b, input samp_t s);
    term_t e;
    e = {s[SAMP_W-1], s};
    return b ? e : -e;
  endfunction

  // Net change of one entry for one window step.
  function automatic delta_t net_delta(input logic bn, input samp_t sn,
                                       input logic bo, input samp_t so);
    term_t tn;
    term_t to;
    tn = signed_term(bn, sn);
    to = signed_term(bo, so);
    return {tn[TERM_W-1], tn} - {to[TERM_W-1], to};
  endfunction

  // Saturating accumulate at the signed accumulator rails.
  function automatic acc_t sat_add(input acc_t a, input delta_t d);
    logic signed [ACC_W:0] s;
    s = $signed({a[ACC_W-1], a}) +
        $signed({{(ACC_W+1-DELTA_W){d[DELTA_W-1]}}, d});
    if (s[ACC_W] != s[ACC_W-1]) return s[ACC_W] ? ACC_MIN : ACC_MAX;
    return s[ACC_W-1:0];
  endfunction
endpackage

// File: rtl/corr_oper_latch.sv
module corr_oper_latch
  import corr_pkg::*;
#(
  parameter int NUM_ROWS = 4,
  parameter int NUM_COLS = 8,
  parameter int ROW_W    = 2,
  parameter int COL_W    = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic [NUM_ROWS-1:0]        bit_new_i,
  input  logic [NUM_ROWS-1:0]        bit_old_i,
  input  logic [NUM_COLS*SAMP_W-1:0] samp_new_i,
  input  logic [NUM_COLS*SAMP_W-1:0] samp_old_i,
  input  logic [ROW_W-1:0]           sel_row,
  input  logic [COL_W-1:0]           sel_col,
  output logic                       sel_bn,
  output logic                       sel_bo,
  output samp_t                      sel_sn,
  output samp_t                      sel_so
);
  logic [NUM_ROWS-1:0]        bn_q, bo_q;
  logic [NUM_COLS*SAMP_W-1:0] sn_q, so_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bn_q <= '0;
      bo_q <= '0;
      sn_q <= '0;
      so_q <= '0;
    end else if (load) begin
      bn_q <= bit_new_i;
      bo_q <= bit_old_i;
      sn_q <= samp_new_i;
      so_q <= samp_old_i;
    end
  end

  always_comb begin
    sel_bn = 1'b0;
    sel_bo = 1'b0;
    sel_sn = '0;
    sel_so = '0;
    if (int'(sel_row) < NUM_ROWS) begin
      sel_bn = bn_q[sel_row];
      sel_bo = bo_q[sel_row];
    end
    if (int'(sel_col) < NUM_COLS) begin
      sel_sn = sn_q[sel_col*SAMP_W +: SAMP_W];
      sel_so = so_q[sel_col*SAMP_W +: SAMP_W];
    end
  end
endmodule

// File: rtl/corr_seq.sv
module corr_seq #(
  parameter int NUM_ROWS = 4,
  parameter int NUM_COLS = 8,
  parameter int ROW_W    = 2,
  parameter int COL_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic             accept_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             wr_en_o,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o
);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(NUM_ROWS - 1);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(NUM_COLS - 1);

  logic busy_q, done_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic col_wrap, sweep_last;

  assign accept_o   = start_i && !busy_q;
  assign col_wrap   = (col_q == COL_LAST);
  assign sweep_last = col_wrap && (row_q == ROW_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      row_q  <= '0;
      col_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept_o) begin
        busy_q <= 1'b1;
        row_q  <= '0;
        col_q  <= '0;
      end else if (busy_q) begin
        if (sweep_last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          row_q  <= '0;
          col_q  <= '0;
        end else if (col_wrap) begin
          col_q <= '0;
          row_q <= row_q + 1'b1;
        end else begin
          col_q <= col_q + 1'b1;
        end
      end
    end
  end

  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign wr_en_o = busy_q;
  assign row_o   = row_q;
  assign col_o   = col_q;
endmodule

// File: rtl/corr_acc_bank.sv
module corr_acc_bank
  import corr_pkg::*;
#(
  parameter int NUM_ROWS = 4,
  parameter int NUM_COLS = 8,
  parameter int ROW_W    = 2,
  parameter int COL_W    = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [ROW_W-1:0]                wr_row,
  input  logic [COL_W-1:0]                wr_col,
  input  delta_t                          delta,
  input  logic [ROW_W-1:0]                rd_row,
  input  logic [COL_W-1:0]                rd_col,
  output acc_t                            rd_data,
  output acc_t                            acc_old,
  output acc_t                            acc_new,
  output logic [NUM_ROWS*NUM_COLS-1:0]    wr_sel
);
  localparam int TOTAL = NUM_ROWS * NUM_COLS;

  acc_t acc_q [TOTAL];
  int   wr_idx, rd_idx;

  always_comb begin
    wr_idx = int'(wr_row) * NUM_COLS + int'(wr_col);
    rd_idx = int'(rd_row) * NUM_COLS + int'(rd_col);
    acc_old = '0;
    rd_data = '0;
    if (wr_idx < TOTAL) acc_old = acc_q[wr_idx];
    if (int'(rd_row) < NUM_ROWS && int'(rd_col) < NUM_COLS) rd_data = acc_q[rd_idx];
  end

  assign acc_new = sat_add(acc_old, delta);

  for (genvar e = 0; e < TOTAL; e++) begin : g_entry
    assign wr_sel[e] = wr_en && (wr_idx == e);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         acc_q[e] <= '0;
      else if (wr_sel[e]) acc_q[e] <= acc_new;
    end
  end
endmodule

// File: rtl/corr_xwin.sv
module corr_xwin
  import corr_pkg::*;
#(
  parameter int NUM_ROWS = 4,
  parameter int NUM_COLS = 8,
  parameter int ROW_W    = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1,
  parameter int COL_W    = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [NUM_ROWS-1:0]        bit_new,
  input  logic [NUM_ROWS-1:0]        bit_old,
  input  logic [NUM_COLS*SAMP_W-1:0] samp_new,
  input  logic [NUM_COLS*SAMP_W-1:0] samp_old,
  input  logic [ROW_W-1:0]           rd_row,
  input  logic [COL_W-1:0]           rd_col,
  output logic [ACC_W-1:0]           rd_data,
  output logic                       busy,
  output logic                       done
);
  // Named internal events, observed by the bound checker.
  logic                          accept;
  logic                          wr_en;
  logic [ROW_W-1:0]              wr_row;
  logic [COL_W-1:0]              wr_col;
  logic                          sel_bn, sel_bo;
  samp_t                         sel_sn, sel_so;
  delta_t                        delta;
  acc_t                          acc_old, acc_new, rd_val;
  logic [NUM_ROWS*NUM_COLS-1:0]  wr_sel;

  corr_seq #(.NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS), .ROW_W(ROW_W), .COL_W(COL_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .accept_o(accept),
    .busy_o(busy), .done_o(done), .wr_en_o(wr_en), .row_o(wr_row), .col_o(wr_col)
  );

  corr_oper_latch #(.NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS), .ROW_W(ROW_W), .COL_W(COL_W)) u_opr (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .bit_new_i(bit_new), .bit_old_i(bit_old), .samp_new_i(samp_new), .samp_old_i(samp_old),
    .sel_row(wr_row), .sel_col(wr_col),
    .sel_bn(sel_bn), .sel_bo(sel_bo), .sel_sn(sel_sn), .sel_so(sel_so)
  );

  assign delta = net_delta(sel_bn, sel_sn, sel_bo, sel_so);

  corr_acc_bank #(.NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS), .ROW_W(ROW_W), .COL_W(COL_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col),
    .delta(delta), .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_val),
    .acc_old(acc_old), .acc_new(acc_new), .wr_sel(wr_sel)
  );

  assign rd_data = rd_val;
endmodule

// File: rtl/corr_xwin_chk.sv
module corr_xwin_chk
  import corr_pkg::*;
#(
  parameter int NUM_ROWS = 4,
  parameter int NUM_COLS = 8,
  parameter int ROW_W    = 2,
  parameter int COL_W    = 3
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         busy,
  input logic                         done,
  input logic                         accept,
  input logic                         wr_en,
  input logic [ROW_W-1:0]             wr_row,
  input logic [COL_W-1:0]             wr_col,
  input delta_t                       delta,
  input acc_t                         acc_old,
  input acc_t                         acc_new,
  input logic [NUM_ROWS*NUM_COLS-1:0] wr_sel
);
  localparam int TOTAL = NUM_ROWS * NUM_COLS;
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(NUM_COLS - 1);

  int busy_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy_cnt <= 0;
    else if (accept) busy_cnt <= 0;
    else if (busy)   busy_cnt <= busy_cnt + 1;
  end

  a_r2_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_cnt == TOTAL);

  a_r3_done_after_sweep: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));

  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !accept);

  a_r7_col_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_col != COL_LAST) |=>
      wr_en && wr_col == $past(wr_col) + 1'b1 && wr_row == $past(wr_row));

  a_r7_one_write: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel));

  a_r5_up_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && delta >= 0) |-> acc_new >= acc_old);

  a_r5_down_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && delta < 0) |-> acc_new <= acc_old);

  a_r5_hold_max: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && acc_old == ACC_MAX && delta > 0) |-> acc_new == ACC_MAX);
endmodule

bind corr_xwin corr_xwin_chk #(
  .NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS), .ROW_W(ROW_W), .COL_W(COL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .accept(accept),
  .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col), .delta(delta),
  .acc_old(acc_old), .acc_new(acc_new), .wr_sel(wr_sel)
);

// File: tb/corr_xwin_tb.sv
module corr_xwin_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 4;
  localparam int NC = 8;
  localparam int TOTAL = NR * NC;
  localparam int RW = 2;
  localparam int CW = 3;

  typedef struct { int row; int col; int value; string tag; } exp_t;

  logic clk = 0, rst_n = 0, start = 0;
  logic [NR-1:0] bit_new = '0, bit_old = '0;
  logic [NC*8-1:0] samp_new = '0, samp_old = '0;
  logic [RW-1:0] rd_row = '0;
  logic [CW-1:0] rd_col = '0;
  logic [15:0] rd_data;
  logic busy, done;

  int n_checks = 0, n_err = 0, cycles = 0;
  int model [NR][NC];
  exp_t exp_q[$];
  bit mon_active = 0;
  int unsigned lcg = 32'h1234_5678;

  corr_xwin #(.NUM_ROWS(NR), .NUM_COLS(NC)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .bit_new(bit_new), .bit_old(bit_old),
    .samp_new(samp_new), .samp_old(samp_old), .rd_row(rd_row), .rd_col(rd_col),
    .rd_data(rd_data), .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int rnd();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return int'(lcg >> 8);
  endfunction

  // Product of a +/-1 bit with a signed byte, written as an integer multiply.
  function automatic int prod(input logic b, input logic [7:0] s);
    int v;
    v = int'($signed(s));
    return (b ? 1 : -1) * v;
  endfunction

  task automatic read_entry(input int r, input int c, output int v);
    rd_row = RW'(r);
    rd_col = CW'(c);
    #1;
    v = int'($signed(rd_data));
  endtask

  // Monitor: pops expected entries when a sweep finishes.
  initial begin
    forever begin
      @(negedge clk);
      if (done && exp_q.size() > 0) begin
        mon_active = 1;
        while (exp_q.size() > 0) begin
          exp_t it;
          int v;
          it = exp_q.pop_front();
          read_entry(it.row, it.col, v);
          check(it.tag, $sformatf("entry(%0d,%0d)", it.row, it.col), v, it.value);
        end
        mon_active = 0;
      end
    end
  end

  // Driver: one window step, model update, push expected items.
  task automatic do_update(input logic [NR-1:0] bn, input logic [NR-1:0] bo,
                           input logic [NC*8-1:0] sn, input logic [NC*8-1:0] so,
                           input bit poke, input bit mid);
    int prev [NR][NC];
    int cnt;
    int v;
    prev = model;
    for (int r = 0; r < NR; r++)
      for (int c = 0; c < NC; c++) begin
        int s;
        exp_t it;
        s = model[r][c] + prod(bn[r], sn[c*8 +: 8]) - prod(bo[r], so[c*8 +: 8]);
        it.tag = "R4";
        if (s > 32767) begin s = 32767; it.tag = "R5"; end
        if (s < -32768) begin s = -32768; it.tag = "R5"; end
        model[r][c] = s;
        it.row = r; it.col = c; it.value = s;
        exp_q.push_back(it);
      end
    @(negedge clk);
    bit_new = bn; bit_old = bo; samp_new = sn; samp_old = so;
    start = 1;
    cnt = 0;
    forever begin
      @(negedge clk);
      start = 0;
      // R2: operands changed during the sweep must not matter
      bit_new = ~bn; samp_new = ~sn;
      if (!busy) break;
      cnt++;
      if (poke && cnt == 10) begin
        start = 1; bit_old = ~bo; samp_old = sn ^ so; // R6 ignored pulse
      end
      if (mid && cnt == 5) begin
        // R7: after 4 writes, index 3 = (0,3) is new and index 4 = (0,4) is old
        read_entry(0, 3, v);
        check("R7", "entry(0,3) mid-sweep", v, model[0][3]);
        read_entry(0, 4, v);
        check("R7", "entry(0,4) mid-sweep", v, prev[0][4]);
      end
    end
    check(poke ? "R6" : "R2", "busy length", cnt, TOTAL);
    check("R3", "done at busy fall", int'(done), 1);
    #2;
    wait (exp_q.size() == 0 && !mon_active);
    @(negedge clk);
    check("R3", "done cleared", int'(done), 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_err++; n_checks++;
        $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
      end
    end
  end

  initial begin
    int v;
    for (int r = 0; r < NR; r++)
      for (int c = 0; c < NC; c++) model[r][c] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", "busy after reset", int'(busy), 0);
    check("R1", "done after reset", int'(done), 0);
    for (int r = 0; r < NR; r++)
      for (int c = 0; c < NC; c++) begin
        read_entry(r, c, v);
        check("R1", $sformatf("reset entry(%0d,%0d)", r, c), v, 0);
      end

    // R4: mixed polarity, ramp samples, nothing leaving
    begin
      logic [NC*8-1:0] sn;
      for (int c = 0; c < NC; c++) sn[c*8 +: 8] = 8'(c * 17 - 60);
      do_update(4'b1010, 4'b0000, sn, '0, 0, 1);
    end
    // R4: pseudo-random steps, one with an ignored start (R6)
    for (int k = 0; k < 6; k++) begin
      logic [NC*8-1:0] sn, so;
      for (int c = 0; c < NC; c++) begin
        sn[c*8 +: 8] = 8'(rnd());
        so[c*8 +: 8] = 8'(rnd());
      end
      do_update(NR'(rnd()), NR'(rnd()), sn, so, k == 2, 0);
    end
    // R4: extreme samples -128 with both polarities
    do_update(4'b0110, 4'b1001, {NC{8'h80}}, {NC{8'h80}}, 0, 0);
    // R5: drive all entries to the positive rail
    for (int k = 0; k < 135; k++)
      do_update({NR{1'b1}}, {NR{1'b0}}, {NC{8'h7F}}, {NC{8'h7F}}, 0, 0);
    read_entry(NR-1, NC-1, v);
    check("R5", "positive rail", v, 32767);
    // R5: then to the negative rail
    for (int k = 0; k < 262; k++)
      do_update({NR{1'b1}}, {NR{1'b0}}, {NC{8'h80}}, {NC{8'h80}}, 0, 0);
    read_entry(0, 0, v);
    check("R5", "negative rail", v, -32768);

    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule